// File: doc/BRIEF.md
# Transmit Lock Controller for a Bus-to-UDP Bridge

This block sits between an on-chip bus and the transmit side of a UDP/IP engine. Each command word arrives with the bus address it was written to. The block uses that address to grant the transmit path to one owner at a time. An agent claims the path with a four-word configuration packet. That packet carries a timeout, the destination IP address, a destination port, a source port and a reply address. Once granted, the agent announces a payload with a header that gives a byte length. It then writes payload words, which are passed straight to the write port of a transmit FIFO. A release packet returns the path to the free state.

Configuration packets are answered with an ack or a nack word on a response stream. The reply goes to the address carried in the packet. While a payload is in progress, words written to other addresses are still decoded as packets, so a competing agent receives its nack without disturbing the transfer. If the owner stalls for longer than its timeout, the block pads the rest of the payload with zero words and raises a timeout pulse.

Top module: `txlock_ctrl`

## Requirements
- R1: While reset is held and right after it, the block is unlocked, `tx_busy` and `resp_valid` are low, `fifo_wr_en` is low and `in_ready` is high.
- R2: The packet type is taken from bits 31..28 of the first word: 0 is configuration, 1 is payload header, 2 is release. Any other type is consumed and dropped, with no response and no state change.
- R3: A configuration accepted while unlocked, or written by the current owner, does four things. It locks the block to the address it was written to. It stores the timeout from word 0 bits 27..0, the destination IP from word 1, the destination port from word 2 bits 31..16 and the source port from word 2 bits 15..0. It replies 0x58000000 (code 5 in bits 31..28, bit 27 set, other bits zero) to the address in word 3.
- R4: A configuration written to any other address while the block is locked receives the reply 0x68000000 at its word-3 address. It leaves the lock and the stored settings unchanged.
- R5: A header from the owner takes a byte length from bits 27..17, and bits 16..0 are ignored. The payload is (length+3)/4 words. A zero length starts no transfer.
- R6: During a transfer, each word written to the owner's address goes to the FIFO unchanged and in order. Words from other addresses are decoded as packets. `tx_done` pulses for one cycle after the last payload word, and FIFO writes only happen while the block is locked.
- R7: A header or release from a non-owner address, or arriving while unlocked, is dropped: no transfer starts and the lock is kept.
- R8: A release from the owner outside a transfer clears the lock and produces no response.
- R9: No FIFO write occurs while `fifo_full` is high. An owner payload word is held off (`in_ready` low) until the FIFO has room.
- R10: The timeout counter reloads on every payload word and holds while the FIFO is full. After timeout+1 idle cycles the block pulses `tx_timeout` and stops accepting input. It then writes zero words for the rest of the payload and ends with `tx_done`.
- R11: `resp_valid` stays high with `resp_data`/`resp_addr` unchanged until `resp_ready`. While a reply is still pending, the last word of a further configuration is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word accepted this cycle when valid |
| in_data | input | 32 | Command or payload word |
| in_addr | input | 32 | Bus address the word was written to |
| fifo_wr_en | output | 1 | Transmit FIFO write strobe |
| fifo_wr_data | output | 32 | Transmit FIFO write data |
| fifo_full | input | 1 | Transmit FIFO cannot take a word |
| resp_valid | output | 1 | Ack/nack word pending |
| resp_ready | input | 1 | Response consumer takes the word |
| resp_data | output | 32 | Ack/nack word |
| resp_addr | output | 32 | Bus address the reply goes to |
| locked | output | 1 | Transmit path owned |
| lock_addr | output | 32 | Owner's bus address |
| dst_ip | output | 32 | Stored destination IP address |
| dst_port | output | 16 | Stored destination UDP port |
| src_port | output | 16 | Stored source UDP port |
| tmo_value | output | 28 | Stored timeout in cycles |
| tx_busy | output | 1 | Payload transfer in progress |
| tx_done | output | 1 | One-cycle pulse at transfer end |
| tx_timeout | output | 1 | One-cycle pulse when padding starts |

## Verification
The checks assume three things about the inputs. The four words of a configuration arrive as one uninterrupted run, with no word from another agent in between. A word offered on the input stays stable until it is accepted. The response consumer eventually raises `resp_ready`. The bench drives each word and holds it until the handshake completes. It sends every configuration as one contiguous run, and it interleaves competing agents only at packet boundaries. It withholds `resp_ready` and `fifo_full` only for bounded stretches, so the hold-off behaviour is exercised without ever starving the block.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam logic [3:0] PT_CFG  = 4'h0;
  localparam logic [3:0] PT_HDR  = 4'h1;
  localparam logic [3:0] PT_REL  = 4'h2;
  localparam logic [3:0] RC_ACK  = 4'h5;
  localparam logic [3:0] RC_NACK = 4'h6;

  typedef enum logic [1:0] {PS_HEAD, PS_W1, PS_W2, PS_W3} pstate_e;
endpackage

// File: rtl/txl_parser.sv
module txl_parser
  import txl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_ready,
  input  logic              locked,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              tx_busy,
  input  logic              tx_pad,
  input  logic              fifo_full,
  input  logic              resp_busy,
  output logic              pay_fire,
  output logic              hdr_fire,
  output logic              rel_fire,
  output logic              w0_fire,
  output logic              w1_fire,
  output logic              w2_fire,
  output logic              cfg_fire,
  output logic              cfg_ok_q,
  output logic [ADDR_W-1:0] cand_addr_q
);
  localparam int TYPE_LSB = DATA_W - 4;

  pstate_e    ps;
  logic [3:0] ptype;
  logic       owner;

  assign ptype = in_data[DATA_W-1:TYPE_LSB];
  assign owner = locked && (in_addr == lock_addr);

  always_comb begin
    in_ready = 1'b0;
    pay_fire = 1'b0;
    hdr_fire = 1'b0;
    rel_fire = 1'b0;
    w0_fire  = 1'b0;
    w1_fire  = 1'b0;
    w2_fire  = 1'b0;
    cfg_fire = 1'b0;
    unique case (ps)
      PS_HEAD: begin
        if (tx_pad) begin
          in_ready = 1'b0;
        end else if (tx_busy && owner) begin
          in_ready = !fifo_full;
          pay_fire = in_valid && !fifo_full;
        end else begin
          in_ready = 1'b1;
          if (in_valid) begin
            unique case (ptype)
              PT_CFG:  w0_fire  = 1'b1;
              PT_HDR:  hdr_fire = owner;
              PT_REL:  rel_fire = owner;
              default: ;
            endcase
          end
        end
      end
      PS_W1: begin
        in_ready = 1'b1;
        w1_fire  = in_valid;
      end
      PS_W2: begin
        in_ready = 1'b1;
        w2_fire  = in_valid;
      end
      PS_W3: begin
        in_ready = !resp_busy;
        cfg_fire = in_valid && !resp_busy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps          <= PS_HEAD;
      cfg_ok_q    <= 1'b0;
      cand_addr_q <= '0;
    end else begin
      unique case (ps)
        PS_HEAD: if (w0_fire) begin
          ps          <= PS_W1;
          cfg_ok_q    <= !locked || owner;
          cand_addr_q <= in_addr;
        end
        PS_W1: if (w1_fire) ps <= PS_W2;
        PS_W2: if (w2_fire) ps <= PS_W3;
        PS_W3: if (cfg_fire) ps <= PS_HEAD;
        default: ps <= PS_HEAD;
      endcase
    end
  end
endmodule

// File: rtl/txl_lock_regs.sv
module txl_lock_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int TMO_W  = 28,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              w0_fire,
  input  logic              w1_fire,
  input  logic              w2_fire,
  input  logic              cfg_fire,
  input  logic              cfg_ok,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic              rel_fire,
  output logic              locked,
  output logic [ADDR_W-1:0] lock_addr,
  output logic [DATA_W-1:0] dst_ip,
  output logic [PORT_W-1:0] dst_port,
  output logic [PORT_W-1:0] src_port,
  output logic [TMO_W-1:0]  tmo_value
);
  logic [TMO_W-1:0]  sh_tmo;
  logic [DATA_W-1:0] sh_ip;
  logic [PORT_W-1:0] sh_dp, sh_sp;
  logic [DATA_W-1:TMO_W] unused_w0;

  assign unused_w0 = in_data[DATA_W-1:TMO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_tmo <= '0;
      sh_ip  <= '0;
      sh_dp  <= '0;
      sh_sp  <= '0;
    end else begin
      if (w0_fire) sh_tmo <= in_data[TMO_W-1:0];
      if (w1_fire) sh_ip  <= in_data;
      if (w2_fire) begin
        sh_dp <= in_data[2*PORT_W-1:PORT_W];
        sh_sp <= in_data[PORT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      lock_addr <= '0;
      dst_ip    <= '0;
      dst_port  <= '0;
      src_port  <= '0;
      tmo_value <= '0;
    end else if (cfg_fire && cfg_ok) begin
      locked    <= 1'b1;
      lock_addr <= cand_addr;
      dst_ip    <= sh_ip;
      dst_port  <= sh_dp;
      src_port  <= sh_sp;
      tmo_value <= sh_tmo;
    end else if (rel_fire) begin
      locked <= 1'b0;
    end
  end
endmodule

// File: rtl/txl_payload.sv
module txl_payload #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 11,
  parameter int TMO_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              pay_fire,
  input  logic [DATA_W-1:0] pay_data,
  input  logic              fifo_full,
  input  logic [TMO_W-1:0]  tmo_value,
  output logic              busy,
  output logic              pad,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              tx_done,
  output logic              tx_timeout
);
  localparam int WCNT_W = LEN_W - 1;

  logic [LEN_W:0]    len_round;
  logic [WCNT_W-1:0] hdr_words;
  logic [WCNT_W-1:0] remain;
  logic [TMO_W-1:0]  timer;
  logic              pad_fire, last;

  assign len_round    = {1'b0, hdr_len} + (LEN_W+1)'(3);
  assign hdr_words    = len_round[LEN_W:2];
  assign pad_fire     = pad && !fifo_full;
  assign last         = (remain == WCNT_W'(1));
  assign fifo_wr_en   = pay_fire || pad_fire;
  assign fifo_wr_data = pay_fire ? pay_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pad        <= 1'b0;
      remain     <= '0;
      timer      <= '0;
      tx_done    <= 1'b0;
      tx_timeout <= 1'b0;
    end else begin
      tx_done    <= 1'b0;
      tx_timeout <= 1'b0;
      if (hdr_fire) begin
        if (hdr_words != '0) begin
          busy   <= 1'b1;
          remain <= hdr_words;
          timer  <= tmo_value;
        end
      end else if (pay_fire || pad_fire) begin
        remain <= remain - WCNT_W'(1);
        timer  <= tmo_value;
        if (last) begin
          busy    <= 1'b0;
          pad     <= 1'b0;
          tx_done <= 1'b1;
        end
      end else if (busy && !pad && !fifo_full) begin
        if (timer == '0) begin
          pad        <= 1'b1;
          tx_timeout <= 1'b1;
        end else begin
          timer <= timer - TMO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/txl_resp.sv
module txl_resp
  import txl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fire,
  input  logic              cfg_ok,
  input  logic [ADDR_W-1:0] reply_addr,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [ADDR_W-1:0] resp_addr
);
  localparam int PAD_W = DATA_W - 5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_addr  <= '0;
    end else if (cfg_fire) begin
      resp_valid <= 1'b1;
      resp_data  <= {(cfg_ok ? RC_ACK : RC_NACK), 1'b1, {PAD_W{1'b0}}};
      resp_addr  <= reply_addr;
    end else if (resp_valid && resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txlock_ctrl.sv
module txlock_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11,
  parameter int TMO_W  = 28,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  input  logic              fifo_full,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              locked,
  output logic [ADDR_W-1:0] lock_addr,
  output logic [DATA_W-1:0] dst_ip,
  output logic [PORT_W-1:0] dst_port,
  output logic [PORT_W-1:0] src_port,
  output logic [TMO_W-1:0]  tmo_value,
  output logic              tx_busy,
  output logic              tx_done,
  output logic              tx_timeout
);
  localparam int LEN_MSB = DATA_W - 5;

  logic              pay_fire, hdr_fire, rel_fire;
  logic              w0_fire, w1_fire, w2_fire, cfg_fire;
  logic              cfg_ok_q, tx_pad;
  logic [ADDR_W-1:0] cand_addr_q;

  txl_parser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_addr(in_addr), .in_ready(in_ready),
    .locked(locked), .lock_addr(lock_addr),
    .tx_busy(tx_busy), .tx_pad(tx_pad), .fifo_full(fifo_full), .resp_busy(resp_valid),
    .pay_fire(pay_fire), .hdr_fire(hdr_fire), .rel_fire(rel_fire),
    .w0_fire(w0_fire), .w1_fire(w1_fire), .w2_fire(w2_fire), .cfg_fire(cfg_fire),
    .cfg_ok_q(cfg_ok_q), .cand_addr_q(cand_addr_q)
  );

  txl_lock_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .in_data(in_data),
    .w0_fire(w0_fire), .w1_fire(w1_fire), .w2_fire(w2_fire),
    .cfg_fire(cfg_fire), .cfg_ok(cfg_ok_q), .cand_addr(cand_addr_q), .rel_fire(rel_fire),
    .locked(locked), .lock_addr(lock_addr), .dst_ip(dst_ip),
    .dst_port(dst_port), .src_port(src_port), .tmo_value(tmo_value)
  );

  txl_payload #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TMO_W(TMO_W)) u_payload (
    .clk(clk), .rst_n(rst_n),
    .hdr_fire(hdr_fire), .hdr_len(in_data[LEN_MSB -: LEN_W]),
    .pay_fire(pay_fire), .pay_data(in_data), .fifo_full(fifo_full),
    .tmo_value(tmo_value), .busy(tx_busy), .pad(tx_pad),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .tx_done(tx_done), .tx_timeout(tx_timeout)
  );

  txl_resp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .cfg_fire(cfg_fire), .cfg_ok(cfg_ok_q), .reply_addr(in_data[ADDR_W-1:0]),
    .resp_ready(resp_ready), .resp_valid(resp_valid),
    .resp_data(resp_data), .resp_addr(resp_addr)
  );
endmodule

// File: rtl/txlock_ctrl_chk.sv
module txlock_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              fifo_wr_en,
  input logic [DATA_W-1:0] fifo_wr_data,
  input logic              fifo_full,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [DATA_W-1:0] resp_data,
  input logic [ADDR_W-1:0] resp_addr,
  input logic              locked,
  input logic              tx_busy,
  input logic              tx_done,
  input logic              tx_timeout
);
  AST_NO_WR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr_en); // R9
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_addr)); // R11
  AST_RESP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_data[DATA_W-5] &&
      (resp_data[DATA_W-1 -: 4] == 4'h5 || resp_data[DATA_W-1 -: 4] == 4'h6)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en && !(in_valid && in_ready) |-> fifo_wr_data == '0); // R10
  AST_TMO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |-> !in_ready); // R10
  AST_WR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> locked); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !tx_busy); // R6
  AST_UNLOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !tx_busy); // R8
endmodule

bind txlock_ctrl txlock_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
  .resp_addr(resp_addr), .locked(locked), .tx_busy(tx_busy),
  .tx_done(tx_done), .tx_timeout(tx_timeout)
);

// File: tb/tb_txlock_ctrl.sv
`timescale 1ns/1ps
module tb_txlock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, fifo_wr_en, fifo_full;
  logic        resp_valid, resp_ready, locked, tx_busy, tx_done, tx_timeout;
  logic [31:0] in_data, in_addr, fifo_wr_data, resp_data, resp_addr, lock_addr, dst_ip;
  logic [15:0] dst_port, src_port;
  logic [27:0] tmo_value;

  always #5 clk = ~clk;

  txlock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_addr(in_addr), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_full(fifo_full), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .resp_addr(resp_addr),
    .locked(locked), .lock_addr(lock_addr), .dst_ip(dst_ip), .dst_port(dst_port),
    .src_port(src_port), .tmo_value(tmo_value), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_timeout(tx_timeout)
  );

  localparam logic [31:0] AG_A = 32'h0123_4567;
  localparam logic [31:0] AG_B = 32'h0123_4568;
  localparam logic [31:0] RP_A = 32'h0000_0A0A;
  localparam logic [31:0] RP_B = 32'h0000_0B0B;
  localparam int NVEC = 7;
  localparam int VEC_LEN[NVEC]   = '{1, 3, 4, 5, 13, 0, 2047};
  localparam int VEC_WORDS[NVEC] = '{1, 1, 1, 2, 4, 0, 512};

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, zero_cnt = 0, done_cnt = 0, tmo_cnt = 0, resp_cnt = 0;
  logic [31:0] last_wr = '0, prev_wr = '0, last_rd = '0, last_ra = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr_en) begin
        wr_cnt++;
        if (fifo_wr_data == 32'h0) zero_cnt++;
        prev_wr = last_wr;
        last_wr = fifo_wr_data;
      end
      if (tx_done) done_cnt++;
      if (tx_timeout) tmo_cnt++;
      if (resp_valid && resp_ready) begin
        resp_cnt++;
        last_rd = resp_data;
        last_ra = resp_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_word(input logic [31:0] a, input logic [31:0] d);
    in_valid = 1'b1;
    in_addr  = a;
    in_data  = d;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_cfg(input logic [31:0] a, input logic [27:0] tmo, input logic [31:0] ip,
                          input logic [15:0] dp, input logic [15:0] sp, input logic [31:0] rp);
    send_word(a, {4'h0, tmo});
    send_word(a, ip);
    send_word(a, {dp, sp});
    send_word(a, rp);
  endtask

  function automatic logic [31:0] hdr(input int len);
    logic [10:0] l = 11'(len);
    return {4'h1, l, 17'h1A5A5};
  endfunction

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int w0, d0, z0, t0, r0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_addr = '0;
    fifo_full = 1'b0; resp_ready = 1'b1;
    settle(3);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 locked", 32'(locked), 0);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 wr_en", 32'(fifo_wr_en), 0);
    rst_n = 1'b1;
    settle(1);
    chk("R1 busy after reset", 32'(tx_busy), 0);

    // R7: header and release while unlocked are dropped; R2: unknown type dropped
    send_word(AG_A, hdr(8));
    settle(1);
    chk("R7 hdr unlocked", 32'(tx_busy), 0);
    send_word(AG_A, 32'h9000_0001);
    send_word(AG_A, 32'h2000_0000);
    settle(3);
    chk("R2 unknown type no resp", 32'(resp_cnt), 0);
    chk("R2 unknown type busy", 32'(tx_busy), 0);

    // R3: accepted configuration
    send_cfg(AG_A, 28'd1000, 32'hC0A8_0102, 16'h1F90, 16'h0457, RP_A);
    settle(3);
    chk("R3 resp count", 32'(resp_cnt), 1);
    chk("R3 ack word", last_rd, 32'h5800_0000);
    chk("R3 ack addr", last_ra, RP_A);
    chk("R3 locked", 32'(locked), 1);
    chk("R3 lock addr", lock_addr, AG_A);
    chk("R3 dst ip", dst_ip, 32'hC0A8_0102);
    chk("R3 dst port", 32'(dst_port), 32'h1F90);
    chk("R3 src port", 32'(src_port), 32'h0457);
    chk("R3 timeout", 32'(tmo_value), 1000);

    // R4: competing configuration is refused
    send_cfg(AG_B, 28'd7, 32'h0A00_0001, 16'h1111, 16'h2222, RP_B);
    settle(3);
    chk("R4 nack word", last_rd, 32'h6800_0000);
    chk("R4 nack addr", last_ra, RP_B);
    chk("R4 lock kept", lock_addr, AG_A);
    chk("R4 ip kept", dst_ip, 32'hC0A8_0102);
    chk("R4 tmo kept", 32'(tmo_value), 1000);

    // R7: non-owner header/release dropped
    send_word(AG_B, hdr(8));
    settle(1);
    chk("R7 hdr non-owner", 32'(tx_busy), 0);
    send_word(AG_B, 32'h2000_0000);
    settle(1);
    chk("R7 rel non-owner", 32'(locked), 1);

    // R5/R6: table of lengths and expected word counts
    for (int k = 0; k < NVEC; k++) begin
      w0 = wr_cnt; d0 = done_cnt;
      send_word(AG_A, hdr(VEC_LEN[k]));
      chk("R5 busy after header", 32'(tx_busy), (VEC_WORDS[k] > 0) ? 1 : 0);
      for (int i = 0; i < VEC_WORDS[k]; i++) send_word(AG_A, 32'hC000_0000 + 32'(i));
      settle(2);
      chk("R5 payload words", 32'(wr_cnt - w0), 32'(VEC_WORDS[k]));
      chk("R6 done pulse", 32'(done_cnt - d0), (VEC_WORDS[k] > 0) ? 1 : 0);
      chk("R6 idle after", 32'(tx_busy), 0);
      if (VEC_WORDS[k] > 0) chk("R6 last data", last_wr, 32'hC000_0000 + 32'(VEC_WORDS[k] - 1));
    end

    // R6/R4: competing configuration interleaved with a payload
    w0 = wr_cnt; r0 = resp_cnt;
    send_word(AG_A, hdr(8));
    send_word(AG_A, 32'hAAAA_0001);
    send_cfg(AG_B, 28'd3, 32'h0B0B_0B0B, 16'h3333, 16'h4444, RP_B);
    send_word(AG_A, 32'h0000_0A02);
    settle(3);
    chk("R6 interleave count", 32'(wr_cnt - w0), 2);
    chk("R6 interleave word0", prev_wr, 32'hAAAA_0001);
    chk("R6 interleave word1", last_wr, 32'h0000_0A02);
    chk("R4 interleave nack", last_rd, 32'h6800_0000);
    chk("R4 interleave resp", 32'(resp_cnt - r0), 1);

    // R9: FIFO full holds off payload
    send_word(AG_A, hdr(4));
    w0 = wr_cnt;
    fifo_full = 1'b1;
    fork
      send_word(AG_A, 32'h5151_5151);
      begin
        settle(4);
        chk("R9 ready low when full", 32'(in_ready), 0);
        chk("R9 no write when full", 32'(wr_cnt - w0), 0);
        fifo_full = 1'b0;
      end
    join
    settle(2);
    chk("R9 write after room", 32'(wr_cnt - w0), 1);
    chk("R9 data", last_wr, 32'h5151_5151);

    // R10: timeout pads with zeros (owner reconfigures with a short timeout)
    send_cfg(AG_A, 28'd5, 32'hC0A8_0102, 16'h1F90, 16'h0457, RP_A);
    settle(3);
    chk("R3 owner reconfig ack", last_rd, 32'h5800_0000);
    w0 = wr_cnt; z0 = zero_cnt; d0 = done_cnt; t0 = tmo_cnt;
    send_word(AG_A, hdr(16));
    send_word(AG_A, 32'h7777_0001);
    begin
      int c = 0;
      while (!tx_timeout && c < 30) begin
        settle(1);
        c++;
      end
      chk("R10 timeout cycles", 32'(c), 6);
      chk("R10 ready low in pad", 32'(in_ready), 0);
    end
    settle(6);
    chk("R10 timeout pulse", 32'(tmo_cnt - t0), 1);
    chk("R10 total words", 32'(wr_cnt - w0), 4);
    chk("R10 zero words", 32'(zero_cnt - z0), 3);
    chk("R10 done", 32'(done_cnt - d0), 1);
    chk("R10 idle", 32'(tx_busy), 0);

    // R8: release by owner, no response
    r0 = resp_cnt;
    send_word(AG_A, 32'h2ABC_DEF0);
    settle(3);
    chk("R8 unlocked", 32'(locked), 0);
    chk("R8 no response", 32'(resp_cnt - r0), 0);

    // R11: response back-pressure
    resp_ready = 1'b0;
    r0 = resp_cnt;
    send_cfg(AG_B, 28'd9, 32'h0A0A_0A0A, 16'h0050, 16'h0051, RP_B);
    fork
      send_cfg(AG_B, 28'd9, 32'h0A0A_0A0A, 16'h0050, 16'h0051, RP_A);
      begin
        settle(8);
        chk("R11 valid held", 32'(resp_valid), 1);
        chk("R11 data held", resp_data, 32'h5800_0000);
        chk("R11 addr held", resp_addr, RP_B);
        chk("R11 last word stalled", 32'(in_ready), 0);
        chk("R11 nothing taken", 32'(resp_cnt - r0), 0);
        resp_ready = 1'b1;
      end
    join
    settle(3);
    chk("R11 both replies", 32'(resp_cnt - r0), 2);
    chk("R11 second reply addr", last_ra, RP_A);
    chk("R3 new owner", lock_addr, AG_B);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule